// File: doc/BRIEF.md
# Two-Register Ring Network Interface

This block sits between one processor element and one ring router. It carries one packet in each direction. The processor stores a packet into an output buffer. The router fills an input buffer that the processor later loads. Each buffer has a one-bit status flag: the flag is 1 while the buffer holds a packet and 0 while it is empty.

On the processor side the block behaves like a small synchronous memory. It has an enable, a write enable, a two-bit register address and a data word in each direction. Loads are registered, so a result appears one clock after the request.

On the router side each direction uses a send/ready pair and a data bus. A packet leaves the output buffer only while the router is ready and the router's polarity input equals the injection polarity. That polarity is fixed by a parameter.

Top module: `ringNic`

## Requirements
- R1: Reset is synchronous and active high. After a reset edge both status flags are 0, `netInReady` is 1, `netOutSend` is 0 and `cpuDataOut` is all zeros.
- R2: A store captures `cpuDataIn` into the output buffer on that clock edge and sets the output status to 1. A store is `cpuEn`=1 and `cpuWrEn`=1 with address 2'b10, made while the output buffer is empty.
- R3: A load is `cpuEn`=1 and `cpuWrEn`=0. On the next edge it drives the addressed register onto `cpuDataOut`. The address map is: 2'b00 input buffer, 2'b01 input status, 2'b10 output buffer, 2'b11 output status.
- R4: A load of either status register (address 2'b01 or 2'b11) returns the flag in bit 0 of `cpuDataOut` and 0 in bits 63..1.
- R5: After an edge where `cpuEn` is 0, or where `cpuWrEn` is 1, `cpuDataOut` is all zeros.
- R6: Illegal accesses are ignored. A store to address 2'b00, 2'b01 or 2'b11 changes no buffer and no flag. A load of address 2'b10 returns all zeros.
- R7: `netInReady` equals the inverse of the input status. When `netInSend` is 1 and `netInReady` is 1, `netInData` is captured into the input buffer on that edge and the input status becomes 1. When `netInSend` is 1 while the buffer is full, the send is ignored.
- R8: `netOutSend` is 1 exactly when the output buffer is full, `netOutReady` is 1 and `netPolarity` equals the parameter `INJECT_POL` (default 0). While `netOutSend` is 1, `netOutData` carries the buffered packet; otherwise it is zero.
- R9: On an edge where `netOutSend` is 1 the output status clears, and the buffer accepts a new store from the next cycle on.
- R10: A store to address 2'b10 while the output buffer is full leaves both the buffer contents and the output status unchanged.
- R11: A load of address 2'b00 while the input status is 1 clears the input status on that edge, so `netInReady` is 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpuEn | input | 1 | Processor access enable |
| cpuWrEn | input | 1 | Processor write enable (store when 1, load when 0) |
| cpuAddr | input | 2 | Register select |
| cpuDataIn | input | 64 | Packet stored by the processor |
| cpuDataOut | output | 64 | Registered load result |
| netInSend | input | 1 | Router presents a packet for the input buffer |
| netInReady | output | 1 | Input buffer is empty |
| netInData | input | 64 | Packet from the router |
| netOutSend | output | 1 | Packet is being injected into the router |
| netOutReady | input | 1 | Router can take a packet |
| netOutData | output | 64 | Packet to the router, zero when not sending |
| netPolarity | input | 1 | Current router polarity |

## Verification
Load results on `cpuDataOut` are due one edge after the request. Status changes from stores, loads and router captures also show one edge later on `netInReady` and `netOutSend`. `netOutSend` and `netOutData` respond to `netOutReady` and `netPolarity` in the same cycle. The bench applies stimulus just after a rising edge and compares every output against its behavioural model at the following falling edge. The model advances at the rising edge, so each output is checked once in the cycle where it is due. Each check is tagged with the rule that produced the expected value and with the scenario's requirement.

// File: rtl/ringNicPkg.sv
package ringNicPkg;
  localparam logic [1:0] ADDR_INBUF   = 2'b00;
  localparam logic [1:0] ADDR_INSTAT  = 2'b01;
  localparam logic [1:0] ADDR_OUTBUF  = 2'b10;
  localparam logic [1:0] ADDR_OUTSTAT = 2'b11;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_INBUF,
    RD_INSTAT,
    RD_OUTSTAT
  } rdSel_e;

  typedef struct packed {
    logic   loadOut;
    logic   loadIn;
    logic   drive;
    rdSel_e rdSel;
  } nicStrobe_t;
endpackage

// File: rtl/ringNicCtrl.sv
module ringNicCtrl
  import ringNicPkg::*;
#(
  parameter logic INJECT_POL = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cpuEn,
  input  logic       cpuWrEn,
  input  logic [1:0] cpuAddr,
  input  logic       netInSend,
  input  logic       netOutReady,
  input  logic       netPolarity,
  output nicStrobe_t strb,
  output logic       inFull,
  output logic       outFull
);
  logic rdReq;
  logic wrReq;
  logic sendNow;
  logic inRelease;

  assign rdReq     = cpuEn & ~cpuWrEn;
  assign wrReq     = cpuEn & cpuWrEn;
  assign sendNow   = outFull & netOutReady & (netPolarity == INJECT_POL);
  assign inRelease = rdReq & (cpuAddr == ADDR_INBUF);

  always_comb begin
    strb.loadOut = wrReq & (cpuAddr == ADDR_OUTBUF) & ~outFull;
    strb.loadIn  = netInSend & ~inFull;
    strb.drive   = sendNow;
    strb.rdSel   = RD_NONE;
    if (rdReq) begin
      unique case (cpuAddr)
        ADDR_INBUF:   strb.rdSel = RD_INBUF;
        ADDR_INSTAT:  strb.rdSel = RD_INSTAT;
        ADDR_OUTSTAT: strb.rdSel = RD_OUTSTAT;
        default:      strb.rdSel = RD_NONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inFull  <= 1'b0;
      outFull <= 1'b0;
    end else begin
      if (strb.loadIn)   inFull <= 1'b1;
      else if (inRelease) inFull <= 1'b0;

      if (strb.loadOut)  outFull <= 1'b1;
      else if (sendNow)  outFull <= 1'b0;
    end
  end
endmodule

// File: rtl/ringNicDatapath.sv
module ringNicDatapath
  import ringNicPkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  nicStrobe_t        strb,
  input  logic              inFull,
  input  logic              outFull,
  input  logic [DATA_W-1:0] cpuDataIn,
  input  logic [DATA_W-1:0] netInData,
  output logic [DATA_W-1:0] cpuDataOut,
  output logic [DATA_W-1:0] netOutData
);
  localparam int PAD_W = DATA_W - 1;

  logic [DATA_W-1:0] inBuf;
  logic [DATA_W-1:0] outBuf;
  logic [DATA_W-1:0] rdData;

  always_comb begin
    unique case (strb.rdSel)
      RD_INBUF:   rdData = inBuf;
      RD_INSTAT:  rdData = {{PAD_W{1'b0}}, inFull};
      RD_OUTSTAT: rdData = {{PAD_W{1'b0}}, outFull};
      default:    rdData = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inBuf      <= '0;
      outBuf     <= '0;
      cpuDataOut <= '0;
    end else begin
      if (strb.loadIn)  inBuf  <= netInData;
      if (strb.loadOut) outBuf <= cpuDataIn;
      cpuDataOut <= rdData;
    end
  end

  assign netOutData = strb.drive ? outBuf : '0;
endmodule

// File: rtl/ringNic.sv
module ringNic
  import ringNicPkg::*;
#(
  parameter int   DATA_W     = 64,
  parameter logic INJECT_POL = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpuEn,
  input  logic              cpuWrEn,
  input  logic [1:0]        cpuAddr,
  input  logic [DATA_W-1:0] cpuDataIn,
  output logic [DATA_W-1:0] cpuDataOut,
  input  logic              netInSend,
  output logic              netInReady,
  input  logic [DATA_W-1:0] netInData,
  output logic              netOutSend,
  input  logic              netOutReady,
  output logic [DATA_W-1:0] netOutData,
  input  logic              netPolarity
);
  nicStrobe_t strb;
  logic       inFull;
  logic       outFull;

  ringNicCtrl #(.INJECT_POL(INJECT_POL)) u_ctrl (
    .clk(clk), .rst(rst), .cpuEn(cpuEn), .cpuWrEn(cpuWrEn), .cpuAddr(cpuAddr),
    .netInSend(netInSend), .netOutReady(netOutReady), .netPolarity(netPolarity),
    .strb(strb), .inFull(inFull), .outFull(outFull)
  );

  ringNicDatapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .inFull(inFull), .outFull(outFull),
    .cpuDataIn(cpuDataIn), .netInData(netInData),
    .cpuDataOut(cpuDataOut), .netOutData(netOutData)
  );

  assign netInReady = ~inFull;
  assign netOutSend = strb.drive;
endmodule

// File: rtl/ringNicChecker.sv
module ringNicChecker #(
  parameter int   DATA_W     = 64,
  parameter logic INJECT_POL = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic              cpuEn,
  input logic              cpuWrEn,
  input logic [1:0]        cpuAddr,
  input logic [DATA_W-1:0] cpuDataOut,
  input logic              netInSend,
  input logic              netInReady,
  input logic              netOutSend,
  input logic              netOutReady,
  input logic              netPolarity,
  input logic              outFull
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (netInReady && !netOutSend && cpuDataOut == '0));

  assert_store_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (cpuEn && cpuWrEn && cpuAddr == 2'b10 && !outFull) |=> outFull);

  assert_status_lsb_R4: assert property (@(posedge clk) disable iff (rst)
    $past(cpuEn && !cpuWrEn && cpuAddr[0]) |-> (cpuDataOut[DATA_W-1:1] == '0));

  assert_idle_zero_R5: assert property (@(posedge clk) disable iff (rst)
    $past(!cpuEn || cpuWrEn) |-> (cpuDataOut == '0));

  assert_capture_full_R7: assert property (@(posedge clk) disable iff (rst)
    (netInSend && netInReady) |=> !netInReady);

  assert_send_gate_R8: assert property (@(posedge clk) disable iff (rst)
    netOutSend |-> (netOutReady && netPolarity == INJECT_POL));

  assert_send_clears_R9: assert property (@(posedge clk) disable iff (rst)
    netOutSend |=> !netOutSend);

  assert_full_holds_R10: assert property (@(posedge clk) disable iff (rst)
    (outFull && !netOutSend) |=> outFull);

  assert_load_frees_R11: assert property (@(posedge clk) disable iff (rst)
    (!netInReady && cpuEn && !cpuWrEn && cpuAddr == 2'b00) |=> netInReady);
endmodule

bind ringNic ringNicChecker #(.DATA_W(DATA_W), .INJECT_POL(INJECT_POL)) u_chk (
  .clk(clk), .rst(rst), .cpuEn(cpuEn), .cpuWrEn(cpuWrEn), .cpuAddr(cpuAddr),
  .cpuDataOut(cpuDataOut), .netInSend(netInSend), .netInReady(netInReady),
  .netOutSend(netOutSend), .netOutReady(netOutReady), .netPolarity(netPolarity),
  .outFull(outFull)
);

// File: tb/ringNic_tb_top.sv
`timescale 1ns/1ps
module ringNic_tb_top;
  localparam int   DW  = 64;
  localparam logic POL = 1'b0;

  logic          clk = 1'b0;
  logic          rst;
  logic          cpuEn, cpuWrEn;
  logic [1:0]    cpuAddr;
  logic [DW-1:0] cpuDataIn, cpuDataOut;
  logic          netInSend, netInReady;
  logic [DW-1:0] netInData, netOutData;
  logic          netOutSend, netOutReady, netPolarity;

  always #2 clk = ~clk;

  ringNic #(.DATA_W(DW), .INJECT_POL(POL)) dut_i (
    .clk(clk), .rst(rst), .cpuEn(cpuEn), .cpuWrEn(cpuWrEn), .cpuAddr(cpuAddr),
    .cpuDataIn(cpuDataIn), .cpuDataOut(cpuDataOut),
    .netInSend(netInSend), .netInReady(netInReady), .netInData(netInData),
    .netOutSend(netOutSend), .netOutReady(netOutReady), .netOutData(netOutData),
    .netPolarity(netPolarity)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string ctx = "R1";

  logic [DW-1:0] mInBuf, mOutBuf, mDout;
  bit            mInFull, mOutFull;
  string         mTag;

  task automatic chk(string sig, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (scenario %s) %s actual=%h expected=%h", tag, ctx, sig, act, exp);
    end
  endtask

  task automatic modelStep();
    bit rd, snd;
    snd = mOutFull && netOutReady && (netPolarity == POL);
    if (rst) begin
      mInBuf = '0; mOutBuf = '0; mInFull = 0; mOutFull = 0; mDout = '0; mTag = "R1";
      return;
    end
    rd = cpuEn && !cpuWrEn;
    if (!rd) begin
      mDout = '0; mTag = "R5";
    end else begin
      case (cpuAddr)
        2'b00: begin mDout = mInBuf; mTag = "R3"; end
        2'b01: begin mDout = DW'(mInFull); mTag = "R4"; end
        2'b10: begin mDout = '0; mTag = "R6"; end
        default: begin mDout = DW'(mOutFull); mTag = "R4"; end
      endcase
    end
    if (netInSend && !mInFull) begin
      mInBuf = netInData; mInFull = 1;
    end else if (rd && cpuAddr == 2'b00) begin
      mInFull = 0;
    end
    if (snd) mOutFull = 0;
    else if (cpuEn && cpuWrEn && cpuAddr == 2'b10 && !mOutFull) begin
      mOutBuf = cpuDataIn; mOutFull = 1;
    end
  endtask

  task automatic cyc(bit en, bit we, logic [1:0] a, logic [DW-1:0] d,
                     bit ns, logic [DW-1:0] nd, bit nr, bit pol);
    bit expSend;
    cpuEn = en; cpuWrEn = we; cpuAddr = a; cpuDataIn = d;
    netInSend = ns; netInData = nd; netOutReady = nr; netPolarity = pol;
    @(negedge clk);
    expSend = mOutFull && nr && (pol == POL);
    chk("cpuDataOut", mTag, cpuDataOut, mDout);
    chk("netInReady", "R7", DW'(netInReady), DW'(!mInFull));
    chk("netOutSend", "R8", DW'(netOutSend), DW'(expSend));
    chk("netOutData", "R8", netOutData, expSend ? mOutBuf : '0);
    @(posedge clk);
    modelStep();
    #1;
  endtask

  initial begin
    rst = 1; cpuEn = 0; cpuWrEn = 0; cpuAddr = 0; cpuDataIn = 0;
    netInSend = 0; netInData = 0; netOutReady = 0; netPolarity = 0;
    @(posedge clk); modelStep(); #1;
    cyc(0,0,2'b00,'0, 0,'0, 0,0);
    rst = 0;
    ctx = "R1";  cyc(0,0,2'b00,'0, 0,'0, 0,0);
    ctx = "R4";  cyc(1,0,2'b01,'0, 0,'0, 0,0);
    cyc(1,0,2'b11,'0, 0,'0, 0,0);
    ctx = "R7";  cyc(0,0,2'b00,'0, 1,64'hA5A5_0001_DEAD_BEEF, 0,0);
    cyc(0,0,2'b00,'0, 1,64'h1111_2222_3333_4444, 0,0);
    ctx = "R4";  cyc(1,0,2'b01,'0, 0,'0, 0,0);
    ctx = "R11"; cyc(1,0,2'b00,'0, 0,'0, 0,0);
    cyc(1,0,2'b01,'0, 0,'0, 0,0);
    ctx = "R2";  cyc(1,1,2'b10,64'hCAFE_0000_0000_0042, 0,'0, 0,0);
    ctx = "R10"; cyc(1,1,2'b10,64'hBAD0_BAD0_BAD0_BAD0, 0,'0, 0,0);
    cyc(1,0,2'b11,'0, 0,'0, 0,0);
    ctx = "R6";  cyc(1,0,2'b10,'0, 0,'0, 0,0);
    ctx = "R8";  cyc(0,0,2'b00,'0, 0,'0, 1,1);
    cyc(0,0,2'b00,'0, 0,'0, 0,0);
    ctx = "R9";  cyc(0,0,2'b00,'0, 0,'0, 1,0);
    cyc(1,0,2'b11,'0, 0,'0, 1,0);
    ctx = "R2";  cyc(1,1,2'b10,64'h0123_4567_89AB_CDEF, 0,'0, 0,0);
    ctx = "R6";  cyc(1,1,2'b00,64'hFFFF_FFFF_FFFF_FFFF, 0,'0, 0,0);
    cyc(1,1,2'b01,64'h1, 0,'0, 0,0);
    cyc(1,1,2'b11,64'h0, 0,'0, 0,0);
    cyc(1,0,2'b00,'0, 0,'0, 0,0);
    cyc(1,0,2'b11,'0, 0,'0, 0,0);
    ctx = "R5";  cyc(0,0,2'b00,'0, 0,'0, 0,0);
    cyc(1,1,2'b00,'0, 0,'0, 0,0);
    ctx = "R7";  cyc(1,0,2'b00,'0, 1,64'h7777_0000_0000_0007, 1,0);
    cyc(1,0,2'b00,'0, 0,'0, 0,0);
    ctx = "R3";
    for (int i = 0; i < 400; i++) begin
      int r = (i * 37 + 11) ^ (i >> 2);
      cyc(r[0] | r[3], r[1], r[5:4], {32'(i), 32'(r)}, r[6], {32'(r), 32'(i)}, r[7] | r[8], r[9]);
    end
    ctx = "R1"; rst = 1; cyc(1,1,2'b10,64'h5, 1,64'h6, 0,0);
    rst = 0; cyc(1,0,2'b01,'0, 0,'0, 0,0);
    cyc(0,0,2'b00,'0, 0,'0, 1,0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (scenario %s) actual=timeout expected=completion", ctx);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule